// File: doc/BRIEF.md
# Precision-Scalable Serial Operand Memory

This block stores the operand words of a bit-serial transform datapath. Each column is a chain of shift stages holding one word; words are written and read one bit per enabled shift, least significant bit first. An eight-way selector in each column picks which stage acts as the serial output tap, and only the stages from that tap to the top of the chain take part in a shift. The stages below the tap hold their contents. A lower precision therefore reads a word in fewer cycles and toggles fewer flops. The stored word recirculates into the top of the chain while it is being read, so a read does not destroy it.

A separate coefficient path streams one constant twiddle word per request from a computed table. It can force the low-order bits of that word to zero, so coefficient precision is set apart from data precision. A sequencer counts the bits of the word in flight, pulses a strobe when the word ends, and accepts a new data precision only between words. Address generation for the transform stages is left to the surrounding controller.

Top module: `sopm_top`

## Requirements
- R1: After reset every stage holds 0, `rd_bits_o` is all zero, and `word_done_o` and `coef_valid_o` are 0.
- R2: A data precision code c (0..7) selects an effective width k = 2*(c+1) bits: code 3 gives 8 bits and code 7 gives 16. A read at width k presents stored bits 16-k up to 15 on `rd_bits_o`, lowest first. Each bit is visible combinationally before the edge that shifts it.
- R3: With `shift_en_i` and `wr_en_i` high, each column takes its `wr_bits_i` bit. After k such shifts the k bits occupy word positions 16-k..15 in write order. A read without `wr_en_i` recirculates the word and leaves it unchanged.
- R4: Stages below the selected tap hold their value during a shift. An 8-bit write leaves bits 0..7 of a stored 16-bit word intact.
- R5: `word_done_o` is high for exactly one cycle, in the cycle after the k-th shift of a word, and at no other time.
- R6: The data precision is sampled at the first shift of a word. Changes on `dprec_i` during the remaining shifts of that word have no effect.
- R7: While `shift_en_i` is low, stored words do not change, whatever `wr_en_i` and `wr_bits_i` do.
- R8: A `coef_start_i` pulse while idle loads table word T(a) = (a*0x3A7D + 0x1357) mod 2^16 for `coef_addr_i` = a. In the following 16 cycles `coef_valid_o` is high and `coef_bit_o` carries bits 0..15 in order. `coef_valid_o` is then low.
- R9: A coefficient precision code p (0..7), sampled with the start pulse, forces bits 0..(16-2*(p+1)-1) of the streamed coefficient to 0. The other bits pass unchanged.
- R10: A `coef_start_i` pulse while `coef_valid_o` is high is ignored. The running stream is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_en_i | input | 1 | Shift all columns by one bit |
| wr_en_i | input | 1 | Take serial input bits instead of recirculating |
| wr_bits_i | input | 4 | Serial write bit, one per column |
| dprec_i | input | 3 | Data precision code, width 2*(code+1) |
| rd_bits_o | output | 4 | Serial read bit, one per column |
| word_done_o | output | 1 | One-cycle strobe after the last bit of a word |
| coef_start_i | input | 1 | Start a coefficient stream |
| coef_addr_i | input | 4 | Coefficient table index |
| cprec_i | input | 3 | Coefficient precision code |
| coef_bit_o | output | 1 | Serial coefficient bit, masked |
| coef_valid_o | output | 1 | Coefficient bit is valid |

## Verification
The hardest situation to reach from the ports is a word written at one width and read back at another. Only then do the held lower stages show whether they kept their contents: a full-width read after a narrow write must return the old low bits beside the new high bits. The stimulus writes full random words and then overwrites them at random narrower widths. Some reads change `dprec_i` after the first shift of a word, and idle stretches drive random write data with shifting off. A second start is pulsed in the middle of some coefficient streams.

// File: rtl/sopm_pkg.sv
package sopm_pkg;
  localparam int unsigned NSEL = 8;

  function automatic logic [31:0] coef_word(input int unsigned a);
    return 32'((a * 32'h3A7D + 32'h1357) & 32'hFFFF);
  endfunction
endpackage

// File: rtl/sopm_column.sv
module sopm_column
  import sopm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic                    wr_en_i,
  input  logic                    wr_bit_i,
  input  logic [$clog2(NSEL)-1:0] sel_i,
  output logic                    rd_bit_o
);
  localparam int unsigned STEP = W / NSEL;

  logic [W-1:0]    stg_q, stg_d;
  logic [NSEL-1:0] tap_v;
  logic            src;
  int              low;

  for (genvar c = 0; c < NSEL; c++) begin : g_tap
    assign tap_v[c] = stg_q[W-(c+1)*STEP];
  end

  assign rd_bit_o = tap_v[sel_i];
  assign src      = wr_en_i ? wr_bit_i : rd_bit_o;

  // only stages at or above the tap move
  always_comb begin
    low   = int'(W) - (int'(sel_i) + 1) * int'(STEP);
    stg_d = stg_q;
    for (int i = 0; i < int'(W) - 1; i++) begin
      if (i >= low) stg_d[i] = stg_q[i+1];
    end
    stg_d[W-1] = src;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stg_q <= '0;
    else if (shift_i) stg_q <= stg_d;
  end

  // R4: lowest stage moves only at full width
  a_r4_low_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sel_i == $clog2(NSEL)'(NSEL-1)) |=> $stable(stg_q[0]));
endmodule

// File: rtl/sopm_ctrl.sv
module sopm_ctrl
  import sopm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic [$clog2(NSEL)-1:0] prec_i,
  output logic [$clog2(NSEL)-1:0] sel_o,
  output logic                    done_o
);
  localparam int unsigned STEP = W / NSEL;
  localparam int unsigned IW   = $clog2(W);
  localparam int unsigned SW   = $clog2(NSEL);

  logic [IW-1:0] cnt_q;
  logic [SW-1:0] prec_q;
  logic          done_q;
  logic [IW-1:0] last_idx;

  // precision is taken live only between words
  assign sel_o    = (cnt_q == '0) ? prec_i : prec_q;
  assign last_idx = IW'((int'(sel_o) + 1) * int'(STEP) - 1);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prec_q <= SW'(NSEL-1);
      done_q <= 1'b0;
    end else begin
      if (cnt_q == '0) prec_q <= prec_i;
      if (shift_i) begin
        if (cnt_q == last_idx) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          done_q <= 1'b0;
        end
      end else begin
        done_q <= 1'b0;
      end
    end
  end

  a_r6_prec_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(prec_q));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(shift_i));
endmodule

// File: rtl/sopm_coef.sv
module sopm_coef
  import sopm_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  input  logic [$clog2(NSEL)-1:0]  prec_i,
  output logic                     bit_o,
  output logic                     valid_o
);
  localparam int unsigned STEP = W / NSEL;
  localparam int unsigned IW   = $clog2(W);

  logic [W-1:0]  word_q;
  logic [IW-1:0] idx_q, zlim_q;
  logic          busy_q;
  logic [31:0]   rom_w;

  assign rom_w   = coef_word(int'(addr_i));
  assign valid_o = busy_q;
  // zero-force mux on the low bits
  assign bit_o   = busy_q && (idx_q >= zlim_q) && word_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      zlim_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        word_q <= rom_w[W-1:0];
        idx_q  <= '0;
        zlim_q <= IW'(int'(W) - (int'(prec_i) + 1) * int'(STEP));
        busy_q <= 1'b1;
      end
    end else if (idx_q == IW'(W-1)) begin
      busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(word_q) && $stable(zlim_q));
  a_r8_stream_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != IW'(W-1)) |=> busy_q);
endmodule

// File: rtl/sopm_top.sv
module sopm_top
  import sopm_pkg::*;
#(
  parameter int unsigned NCOL       = 4,
  parameter int unsigned W          = 16,
  parameter int unsigned COEF_DEPTH = 16,
  localparam int unsigned SW        = $clog2(NSEL),
  localparam int unsigned AW        = $clog2(COEF_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_en_i,
  input  logic            wr_en_i,
  input  logic [NCOL-1:0] wr_bits_i,
  input  logic [SW-1:0]   dprec_i,
  output logic [NCOL-1:0] rd_bits_o,
  output logic            word_done_o,
  input  logic            coef_start_i,
  input  logic [AW-1:0]   coef_addr_i,
  input  logic [SW-1:0]   cprec_i,
  output logic            coef_bit_o,
  output logic            coef_valid_o
);
  logic [SW-1:0] sel;

  sopm_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en_i),
    .prec_i (dprec_i),
    .sel_o  (sel),
    .done_o (word_done_o)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    sopm_column #(.W(W)) u_col (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (shift_en_i),
      .wr_en_i (wr_en_i),
      .wr_bit_i(wr_bits_i[c]),
      .sel_i   (sel),
      .rd_bit_o(rd_bits_o[c])
    );
  end

  sopm_coef #(.W(W), .DEPTH(COEF_DEPTH)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(coef_start_i),
    .addr_i (coef_addr_i),
    .prec_i (cprec_i),
    .bit_o  (coef_bit_o),
    .valid_o(coef_valid_o)
  );

  a_r8_bit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_bit_o |-> coef_valid_o);
endmodule

// File: tb/sopm_top_test.sv
`timescale 1ns/1ps
module sopm_top_test;
  localparam int NCOL = 4;
  localparam int W    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            shift_en = 1'b0, wr_en = 1'b0;
  logic [NCOL-1:0] wr_bits = '0;
  logic [2:0]      dprec = 3'd7;
  logic [NCOL-1:0] rd_bits;
  logic            word_done;
  logic            coef_start = 1'b0;
  logic [3:0]      coef_addr = '0;
  logic [2:0]      cprec = 3'd7;
  logic            coef_bit, coef_valid;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [W-1:0] model [NCOL];

  always #2.5 clk = ~clk;

  sopm_top uut (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(shift_en), .wr_en_i(wr_en),
    .wr_bits_i(wr_bits), .dprec_i(dprec), .rd_bits_o(rd_bits),
    .word_done_o(word_done), .coef_start_i(coef_start),
    .coef_addr_i(coef_addr), .cprec_i(cprec), .coef_bit_o(coef_bit),
    .coef_valid_o(coef_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] c);
    return 2 * (int'(c) + 1);
  endfunction

  function automatic logic [15:0] table_word(input int a);
    return 16'((a * 32'h3A7D + 32'h1357) & 32'hFFFF);
  endfunction

  // R3: write k bits into every column, bits land in positions 16-k..15
  task automatic write_words(input logic [W-1:0] w [NCOL], input logic [2:0] code);
    int k = width_of(code);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      shift_en = 1'b1; wr_en = 1'b1; dprec = code;
      for (int c = 0; c < NCOL; c++) begin
        wr_bits[c] = w[c][W-k+j];
        model[c][W-k+j] = w[c][W-k+j];
      end
      @(posedge clk);
    end
    @(negedge clk);
    shift_en = 1'b0; wr_en = 1'b0;
    #1 chk(word_done == 1'b1, "R5 done after write", word_done, 1);
  endtask

  // R2/R6: read k bits; optionally disturb dprec after first shift
  task automatic read_words(input logic [2:0] code, input bit disturb, input string req);
    int k = width_of(code);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      shift_en = 1'b1; wr_en = 1'b0;
      dprec = (disturb && j > 0) ? 3'($urandom_range(0, 7)) : code;
      #1;
      for (int c = 0; c < NCOL; c++)
        chk(rd_bits[c] == model[c][W-k+j], req, rd_bits[c], model[c][W-k+j]);
      if (j > 0) chk(word_done == 1'b0, "R5 no early done", word_done, 0);
      @(posedge clk);
    end
    @(negedge clk);
    shift_en = 1'b0; dprec = code;
    #1 chk(word_done == 1'b1, "R5 done after read", word_done, 1);
    @(negedge clk);
    #1 chk(word_done == 1'b0, "R5 done one cycle", word_done, 0);
  endtask

  // R7: idle cycles with junk write data
  task automatic idle_junk(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      shift_en = 1'b0; wr_en = 1'b1;
      wr_bits = NCOL'($urandom);
      dprec = 3'($urandom_range(0, 7));
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R8/R9/R10: stream one coefficient
  task automatic coef_run(input int a, input logic [2:0] p, input bit poke);
    logic [15:0] t = table_word(a);
    int zl = W - width_of(p);
    @(negedge clk);
    coef_start = 1'b1; coef_addr = 4'(a); cprec = p;
    @(negedge clk);
    coef_start = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (poke && b == 3) begin
        coef_start = 1'b1; coef_addr = 4'(a + 5); cprec = 3'd7;
      end else begin
        coef_start = 1'b0;
      end
      #1;
      chk(coef_valid == 1'b1, "R8 valid", coef_valid, 1);
      if (b < zl) chk(coef_bit == 1'b0, "R9 low bit zero", coef_bit, 0);
      else chk(coef_bit == t[b], poke ? "R10 stream kept" : "R8 coef bit", coef_bit, t[b]);
      @(negedge clk);
    end
    coef_start = 1'b0;
    #1 chk(coef_valid == 1'b0, "R8 end of stream", coef_valid, 0);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] w [NCOL];
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCOL; c++) model[c] = '0;
    #12;
    chk(rd_bits == '0, "R1 rd_bits reset", rd_bits, 0);
    chk(word_done == 1'b0, "R1 done reset", word_done, 0);
    chk(coef_valid == 1'b0, "R1 coef_valid reset", coef_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    read_words(3'd7, 1'b0, "R1 stored zero");

    // directed: full write, 8-bit overwrite, full read
    for (int c = 0; c < NCOL; c++) w[c] = 16'hA5C3 ^ 16'(c * 16'h1111);
    write_words(w, 3'd7);
    read_words(3'd7, 1'b0, "R2 full read");
    read_words(3'd7, 1'b0, "R3 non-destructive");
    for (int c = 0; c < NCOL; c++) w[c] = 16'h3C00 + 16'(c << 12);
    write_words(w, 3'd3);
    read_words(3'd7, 1'b0, "R4 low byte kept");
    read_words(3'd3, 1'b0, "R2 8-bit read");
    read_words(3'd0, 1'b0, "R2 2-bit read");
    idle_junk(6);
    read_words(3'd7, 1'b0, "R7 idle hold");
    read_words(3'd3, 1'b1, "R6 mid-word change");
    read_words(3'd7, 1'b0, "R6 word intact");

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [2:0] wc = 3'($urandom_range(0, 7));
      logic [2:0] rc = 3'($urandom_range(0, 7));
      for (int c = 0; c < NCOL; c++) w[c] = 16'($urandom);
      write_words(w, wc);
      if (it % 4 == 0) idle_junk(3);
      read_words(rc, it % 3 == 0, "R2 random read");
      read_words(3'd7, 1'b0, "R4 random full read");
    end

    // coefficients
    coef_run(0, 3'd7, 1'b0);
    coef_run(9, 3'd3, 1'b0);
    coef_run(15, 3'd0, 1'b0);
    coef_run(6, 3'd5, 1'b1);
    for (int it = 0; it < 20; it++)
      coef_run($urandom_range(0, 15), 3'($urandom_range(0, 7)), it % 5 == 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule